// File: doc/BRIEF.md
# Bit-Ring Clock Hold Controller

This controller decides, cycle by cycle, whether the bit and digit rings of a read channel may advance. The phase pulses that clock the channel keep running without a break. What this block does is hold the ring still at two fixed timing points in every record, so that a medium with a fixed clock-to-data relationship produces the same ring timing as a device whose data arrives later.

The first hold point is the preamble burst. The preamble freeze condition is info-search, at the first digit and first bit. It stops the ring at the sync slot of the second digit. The second hold point is the missing-sync gap. It is detected when the second stage of the gap-detection chain is set and the third stage is not yet set. In both cases a freeze flag is set. The ring may move again only after the next sync bit read from the data clears that flag. After that, an area or check-prep signal restarts the run flag.

The hold logic acts only while the drum is on line and a read is in progress. Machine-idle reset clears both flags.

Top module: `ring_hold_ctrl`

## Requirements
- R1: While `idle_rst` is high at a clock edge, both `step_en` and `frozen` are 0 after that edge. After reset, `step_en` stays 0 until a start signal (`area` or `check_prep`) is sampled while `frozen` is 0.
- R2: When `drum_online`, `read_mode`, `info_search`, `digit_d1` and `bit_b1` are all 1 at an edge, then `frozen` is 1 and `step_en` is 0 after that edge. If any one of these inputs is 0, the preamble freeze does not happen.
- R3: When `drum_online` and `read_mode` are 1, `gap_t2` is 1 and `gap_t3` is 0 at an edge, then `frozen` is 1 and `step_en` is 0 after that edge. With both `gap_t2` and `gap_t3` at 1, no freeze happens.
- R4: While `frozen` is 1, `step_en` is 0 after the next edge. Start signals do not set it.
- R5: A `sync_bit` pulse sampled while `frozen` is 1, with no freeze condition present, clears `frozen` at that edge. `step_en` stays 0 at that edge. `step_en` can rise at the following edge if a start signal is present then.
- R6: With `frozen` at 0, `area` or `check_prep` at an edge sets `step_en` to 1. It then stays 1 after the start signal drops, until a freeze or a reset.
- R7: When `drum_online` or `read_mode` is 0, neither freeze condition has any effect, and `frozen` is cleared at the next edge. Start signals still set `step_en`.
- R8: When a freeze condition and `sync_bit` arrive at the same edge, the freeze wins and `frozen` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| idle_rst | input | 1 | Machine-idle reset, synchronous, active high |
| drum_online | input | 1 | Drum selected and on line |
| read_mode | input | 1 | Read operation in progress |
| info_search | input | 1 | Info-search state |
| digit_d1 | input | 1 | Digit ring at first digit |
| bit_b1 | input | 1 | Bit ring at first bit |
| gap_t2 | input | 1 | Gap-chain second stage set |
| gap_t3 | input | 1 | Gap-chain third stage set |
| sync_bit | input | 1 | First read-data sync bit pulse |
| area | input | 1 | Address or record area signal |
| check_prep | input | 1 | Check-prep signal |
| step_en | output | 1 | Ring step enable (registered run flag) |
| frozen | output | 1 | Block-read-clock flag |

## Verification
The bench tests start signals arriving during a freeze. A design that let them through would restart the ring before the data sync bit arrived. It tests the release timing after a sync bit. Here a design off by one cycle would resume one step early or one step late. It tests a freeze and a sync bit arriving together, where a design with the wrong priority would never freeze. It tests both gap stages set at once, where a design that ignored the third stage would freeze the ring after the gap has ended. It also tests freeze conditions while the drum is off line or not reading, and a reset in the middle of a freeze. In either case a faulty design would leave the ring held.

// File: rtl/ring_hold_ctrl.sv
module ring_hold_ctrl (
  input  logic clk,
  input  logic idle_rst,
  input  logic drum_online,
  input  logic read_mode,
  input  logic info_search,
  input  logic digit_d1,
  input  logic bit_b1,
  input  logic gap_t2,
  input  logic gap_t3,
  input  logic sync_bit,
  input  logic area,
  input  logic check_prep,
  output logic step_en,
  output logic frozen
);

  logic active, pre_hit, gap_hit, hold_set, start;
  logic blk_q, run_q;

  assign active   = drum_online & read_mode;
  assign pre_hit  = info_search & digit_d1 & bit_b1;
  assign gap_hit  = gap_t2 & ~gap_t3;
  assign hold_set = active & (pre_hit | gap_hit);
  assign start    = area | check_prep;

  always_ff @(posedge clk) begin
    if (idle_rst)      blk_q <= 1'b0;
    else if (hold_set) blk_q <= 1'b1;
    else if (!active)  blk_q <= 1'b0;
    else if (sync_bit) blk_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (idle_rst)               run_q <= 1'b0;
    else if (hold_set || blk_q) run_q <= 1'b0;
    else if (start)             run_q <= 1'b1;
  end

  assign step_en = run_q;
  assign frozen  = blk_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    idle_rst |=> (!step_en && !frozen));

  p_preamble_freeze_r2: assert property (@(posedge clk) disable iff (idle_rst)
    (drum_online && read_mode && info_search && digit_d1 && bit_b1) |=> (frozen && !step_en));

  p_gap_freeze_r3: assert property (@(posedge clk) disable iff (idle_rst)
    (drum_online && read_mode && gap_t2 && !gap_t3) |=> (frozen && !step_en));

  p_frozen_stops_r4: assert property (@(posedge clk) disable iff (idle_rst)
    frozen |=> !step_en);

  p_sync_release_r5: assert property (@(posedge clk) disable iff (idle_rst)
    (frozen && sync_bit && !(info_search && digit_d1 && bit_b1) && !(gap_t2 && !gap_t3))
      |=> (!frozen && !step_en));

  p_run_holds_r6: assert property (@(posedge clk) disable iff (idle_rst)
    (step_en && !(drum_online && read_mode && ((info_search && digit_d1 && bit_b1) || (gap_t2 && !gap_t3))))
      |=> step_en);

  p_inactive_clear_r7: assert property (@(posedge clk) disable iff (idle_rst)
    !(drum_online && read_mode) |=> !frozen);

  p_freeze_over_sync_r8: assert property (@(posedge clk) disable iff (idle_rst)
    (drum_online && read_mode && gap_t2 && !gap_t3 && sync_bit) |=> frozen);

endmodule

// File: tb/ring_hold_ctrl_tb.sv
module ring_hold_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;
  // fields: [16:13] req, [12:2] {idle,drum,read,info,d1,b1,t2,t3,sync,area,prep}, [1:0] {step_en,frozen}
  localparam logic [16:0] VEC [NVEC] = '{
    {4'd1, 11'b10000000000, 2'b00}, // R1 reset
    {4'd6, 11'b01100000010, 2'b10}, // R6 area starts
    {4'd6, 11'b01100000000, 2'b10}, // R6 run holds
    {4'd2, 11'b01111100000, 2'b01}, // R2 preamble freeze
    {4'd4, 11'b01100000010, 2'b01}, // R4 area ignored while frozen
    {4'd4, 11'b01100000001, 2'b01}, // R4 prep ignored while frozen
    {4'd5, 11'b01100000100, 2'b00}, // R5 sync releases
    {4'd5, 11'b01100000010, 2'b10}, // R5 resume one edge later
    {4'd3, 11'b01100011000, 2'b10}, // R3 t2&t3 no freeze
    {4'd3, 11'b01100010000, 2'b01}, // R3 gap freeze
    {4'd8, 11'b01100010100, 2'b01}, // R8 freeze beats sync
    {4'd5, 11'b01100000100, 2'b00}, // R5 release
    {4'd6, 11'b01100000001, 2'b10}, // R6 check_prep starts
    {4'd7, 11'b00111100000, 2'b10}, // R7 drum off line
    {4'd7, 11'b01011110000, 2'b10}, // R7 not reading
    {4'd2, 11'b01111000000, 2'b10}, // R2 missing bit_b1
    {4'd1, 11'b11100000010, 2'b00}, // R1 reset beats start
    {4'd1, 11'b01100000000, 2'b00}, // R1 stays clear
    {4'd3, 11'b01100010000, 2'b01}, // R3 freeze again
    {4'd7, 11'b00100000000, 2'b00}, // R7 inactive clears freeze
    {4'd7, 11'b00100000010, 2'b10}  // R7 start works when inactive
  };

  logic clk = 1'b0;
  logic idle_rst, drum_online, read_mode, info_search, digit_d1, bit_b1;
  logic gap_t2, gap_t3, sync_bit, area, check_prep;
  logic step_en, frozen;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_hold_ctrl dut_i (
    .clk(clk), .idle_rst(idle_rst), .drum_online(drum_online), .read_mode(read_mode),
    .info_search(info_search), .digit_d1(digit_d1), .bit_b1(bit_b1),
    .gap_t2(gap_t2), .gap_t3(gap_t3), .sync_bit(sync_bit), .area(area),
    .check_prep(check_prep), .step_en(step_en), .frozen(frozen)
  );

  task automatic apply(input logic [10:0] v);
    @(negedge clk);
    {idle_rst, drum_online, read_mode, info_search, digit_d1, bit_b1,
     gap_t2, gap_t3, sync_bit, area, check_prep} = v;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int req, input logic [1:0] exp);
    checks++;
    if ({step_en, frozen} !== exp) begin
      errors++;
      $display("FAIL R%0d: {step_en,frozen} actual=%b expected=%b", req, {step_en, frozen}, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    apply(11'b10000000000);
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][12:2]);
      check(int'(VEC[i][16:13]), VEC[i][1:0]);
    end
    // R1: reset in the middle of a freeze
    apply(11'b01100000010); check(1, 2'b10);
    apply(11'b01100010000); check(3, 2'b01);
    apply(11'b11100000010); check(1, 2'b00);
    apply(11'b01100000010); check(1, 2'b10);
    // R8: preamble freeze together with sync bit
    apply(11'b01111100100); check(8, 2'b01);
    apply(11'b01100000100); check(5, 2'b00);
    apply(11'b01100000000); check(5, 2'b00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule